// File: doc/BRIEF.md
# Write Data Precompensation Unit

This block sits in a disk write path between the run-length-limited encoder and the output driver. Each bit period it takes at most one encoded channel bit and turns every '1' into a one-tick write strobe on a fast clock. The fast clock runs at a fixed number of ticks per bit period, eight by default. A '1' bit normally fires on the first tick of its period.

Encoded data never holds two adjacent '1' bits, so the closest transitions are a '1', a '0' and a '1' in consecutive slots. When the block sees that pattern, it moves the strobe of the second '1' onto a late timing path. That path fires a programmable number of ticks after the nominal tick. A multiplexer picks the nominal or the late path for each bit. The delay value is captured when the bit is accepted, so a change during a bit period cannot corrupt a bit already in flight. If an input breaks the no-adjacent-ones rule, the block raises a sticky error flag and sends the bit on the nominal path.

Top module: `write_precomp`

## Requirements
- R1: Reset drives `in_ready` high, `wr_strobe` low and `rule_err` low, and clears the bit history. The first '1' accepted after reset is therefore launched on tick 0, whatever the delay setting.
- R2: `in_ready` is high on exactly one cycle per bit period, the last tick (tick TICKS-1). A bit is accepted at a rising edge where `in_valid` and `in_ready` are both high, and the next cycle is tick 0 of that bit's period.
- R3: An accepted '1' produces exactly one strobe pulse, one cycle wide, within its own period. An accepted '0' or an idle slot produces no pulse.
- R4: A '1' that does not complete a '1','0','1' sequence fires on tick 0, the first cycle after acceptance.
- R5: A '1' accepted when the previous slot held '0' and the slot before that held '1' fires on tick `shift_dly`, a 3-bit value from 0 to 7.
- R6: A `shift_dly` of 0 disables compensation, so a pattern bit fires on tick 0.
- R7: `shift_dly` is sampled only at acceptance. A change during the period has no effect on the bit in flight.
- R8: An idle slot (`in_valid` low while `in_ready` is high) counts as a '0' in the history, and the value on `in_bit` is ignored.
- R9: Accepting a '1' directly after an accepted '1' sets `rule_err`. That bit fires on tick 0. `rule_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An encoded bit is offered |
| in_bit | input | 1 | Encoded channel bit |
| in_ready | output | 1 | High on the last tick of each period; acceptance point |
| shift_dly | input | 3 | Extra ticks applied to a compensated bit |
| wr_strobe | output | 1 | One-tick write strobe |
| rule_err | output | 1 | Sticky flag for adjacent '1' bits |

## Verification
The assertions assume that the offered bit and the delay value are stable across the acceptance edge. They assume nothing else about `in_bit`, so adjacent '1' bits are legal stimulus, and the checker confirms that such bits raise the flag and fall back to tick 0. The bench changes inputs only on falling edges, and it presents a new bit only on a falling edge where `in_ready` is already high. It holds every value until after the following rising edge. It feeds pattern, idle, zero-delay, mid-period delay change and rule-breaking slots, and counts the strobe pulses and records the tick of each one in every period.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  // second '1' of a one-zero-one run: new bit set, last slot clear, slot before set
  function automatic logic is_spread_pair(input logic new_bit,
                                          input logic hist_last,
                                          input logic hist_prev);
    return new_bit & ~hist_last & hist_prev;
  endfunction

  // two adjacent ones break the encoder run-length rule
  function automatic logic breaks_rule(input logic new_bit,
                                       input logic hist_last);
    return new_bit & hist_last;
  endfunction

  // which path the selector takes for one bit
  typedef enum logic {PATH_NOMINAL = 1'b0, PATH_LATE = 1'b1} path_e;

endpackage

// File: rtl/wpc_slot_timer.sv
module wpc_slot_timer #(
  parameter int TICKS = 8,
  parameter int TW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] tick,
  output logic          slot_end
);
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  // reset parks on the last tick so the first acceptance point is immediate
  always_ff @(posedge clk) begin
    if (!rst_n)            tick <= LAST;
    else if (tick == LAST) tick <= '0;
    else                   tick <= tick + 1'b1;
  end

  assign slot_end = (tick == LAST);
endmodule

// File: rtl/wpc_pattern_det.sv
module wpc_pattern_det
  import wpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slot_end,
  input  logic accept,
  input  logic in_bit,
  output logic comp_take,
  output logic rule_hit,
  output logic last_one,
  output logic rule_err
);
  logic hist_last;
  logic hist_prev;

  // an idle slot shifts a zero, as time without a transition
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_last <= 1'b0;
      hist_prev <= 1'b0;
    end else if (slot_end) begin
      hist_prev <= hist_last;
      hist_last <= accept & in_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  rule_err <= 1'b0;
    else if (accept && rule_hit) rule_err <= 1'b1;
  end

  assign comp_take = is_spread_pair(in_bit, hist_last, hist_prev);
  assign rule_hit  = breaks_rule(in_bit, hist_last);
  assign last_one  = hist_last;
endmodule

// File: rtl/wpc_launch_sel.sv
module wpc_launch_sel
  import wpc_pkg::*;
#(
  parameter int TICKS = 8,
  parameter int TW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_end,
  input  logic          accept,
  input  logic          in_bit,
  input  logic          comp_take,
  input  logic          rule_hit,
  input  logic [TW-1:0] shift_dly,
  input  logic [TW-1:0] tick,
  output logic          wr_strobe
);
  localparam logic [TW-1:0] NOM_TICK = '0;

  function automatic logic [TW-1:0] clamp_dly(input logic [TW-1:0] d);
    if (int'(d) > TICKS - 1) return TW'(TICKS - 1);
    return d;
  endfunction

  logic          cur_one;
  path_e         cur_path;
  logic [TW-1:0] late_tick;
  logic          nom_fire;
  logic          late_fire;

  // bit, path and delay are frozen at acceptance for the whole period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_one   <= 1'b0;
      cur_path  <= PATH_NOMINAL;
      late_tick <= NOM_TICK;
    end else if (slot_end) begin
      cur_one   <= accept & in_bit;
      cur_path  <= (accept && comp_take && !rule_hit) ? PATH_LATE : PATH_NOMINAL;
      late_tick <= clamp_dly(shift_dly);
    end
  end

  assign nom_fire  = (tick == NOM_TICK);
  assign late_fire = (tick == late_tick);

  always_comb begin
    unique case (cur_path)
      PATH_LATE: wr_strobe = cur_one & late_fire;
      default:   wr_strobe = cur_one & nom_fire;
    endcase
  end
endmodule

// File: rtl/write_precomp.sv
module write_precomp #(
  parameter int TICKS = 8,
  parameter int TW    = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_bit,
  output logic          in_ready,
  input  logic [TW-1:0] shift_dly,
  output logic          wr_strobe,
  output logic          rule_err
);
  logic [TW-1:0] tick;
  logic          slot_end;
  logic          accept;
  logic          comp_take;
  logic          rule_hit;
  logic          last_one;

  wpc_slot_timer #(.TICKS(TICKS), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slot_end(slot_end)
  );

  assign in_ready = slot_end;
  assign accept   = in_valid & slot_end;

  wpc_pattern_det u_det (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .accept(accept),
    .in_bit(in_bit), .comp_take(comp_take), .rule_hit(rule_hit),
    .last_one(last_one), .rule_err(rule_err)
  );

  wpc_launch_sel #(.TICKS(TICKS), .TW(TW)) u_launch (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .accept(accept),
    .in_bit(in_bit), .comp_take(comp_take), .rule_hit(rule_hit),
    .shift_dly(shift_dly), .tick(tick), .wr_strobe(wr_strobe)
  );
endmodule

// File: rtl/write_precomp_chk.sv
module write_precomp_chk #(
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          in_valid,
  input logic          in_bit,
  input logic [TW-1:0] shift_dly,
  input logic          wr_strobe,
  input logic          rule_err,
  input logic          accept,
  input logic          comp_take,
  input logic          last_one
);
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n)         seen <= 1'b0;
    else if (in_ready)  seen <= 1'b0;
    else if (wr_strobe) seen <= 1'b1;
  end

  AST_READY_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n) in_ready |=> !in_ready); // R2
  AST_ONE_PULSE_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n) wr_strobe |-> !seen); // R3
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (accept && !in_bit) |=> !wr_strobe); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (in_ready && !in_valid) |=> !wr_strobe); // R8
  AST_NOMINAL_TICK0: assert property (@(posedge clk) disable iff (!rst_n) (accept && in_bit && !comp_take) |=> wr_strobe); // R4
  AST_COMP_LATE: assert property (@(posedge clk) disable iff (!rst_n) (accept && in_bit && comp_take && shift_dly != '0) |=> !wr_strobe); // R5
  AST_DLY_ZERO_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n) (accept && in_bit && shift_dly == '0) |=> wr_strobe); // R6
  AST_RULE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (accept && in_bit && last_one) |=> rule_err); // R9
  AST_RULE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rule_err |=> rule_err); // R9
endmodule

bind write_precomp write_precomp_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .in_valid(in_valid),
  .in_bit(in_bit), .shift_dly(shift_dly), .wr_strobe(wr_strobe),
  .rule_err(rule_err), .accept(accept), .comp_take(comp_take),
  .last_one(last_one)
);

// File: tb/test_write_precomp.sv
`timescale 1ns/1ps
module test_write_precomp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic [2:0] shift_dly = 3'd0;
  logic       in_ready;
  logic       wr_strobe;
  logic       rule_err;
  int         total = 0;
  int         bad = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  write_precomp i_write_precomp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .shift_dly(shift_dly), .wr_strobe(wr_strobe),
    .rule_err(rule_err)
  );

  // {valid, bit, delay[2:0], expected tick[3:0]}; tick 8 means no pulse
  localparam logic [8:0] VEC [0:15] = '{
    9'b1_1_011_0000, 9'b1_0_011_1000, 9'b1_1_011_0011, 9'b1_0_101_1000,
    9'b1_1_101_0101, 9'b1_0_000_1000, 9'b1_1_000_0000, 9'b1_0_111_1000,
    9'b1_1_111_0111, 9'b0_1_111_1000, 9'b1_1_111_0111, 9'b0_0_000_1000,
    9'b0_0_000_1000, 9'b1_1_100_0000, 9'b1_0_100_1000, 9'b1_1_010_0010
  };

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // entered on a falling edge with in_ready high; leaves on the next such edge
  task automatic run_slot(input logic v, input logic b, input logic [2:0] d,
                          input logic [2:0] d_mid, input int exp_tick,
                          input logic exp_err, input string req);
    int pulses = 0;
    int first = 8;
    int ready_bad = 0;
    in_valid  = v;
    in_bit    = b;
    shift_dly = d;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      if (t == 0) begin
        in_valid  = 1'b0;
        shift_dly = d_mid;
      end
      if (wr_strobe) begin
        if (first == 8) first = t;
        pulses++;
      end
      if (in_ready != (t == 7)) ready_bad++;
    end
    check(ready_bad == 0, "R2", "ready on last tick only", ready_bad, 0);
    if (exp_tick == 8)
      check(pulses == 0, req, "pulse count", pulses, 0);
    else begin
      check(pulses == 1, req, "pulse count", pulses, 1);
      check(first == exp_tick, req, "strobe tick", first, exp_tick);
    end
    check(rule_err == exp_err, req, "error flag", int'(rule_err), int'(exp_err));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    check(wr_strobe == 1'b0, "R1", "strobe after reset", int'(wr_strobe), 0);
    check(rule_err == 1'b0, "R1", "error after reset", int'(rule_err), 0);

    for (int i = 0; i < 16; i++)
      run_slot(VEC[i][8], VEC[i][7], VEC[i][6:4], VEC[i][6:4],
               int'(VEC[i][3:0]), 1'b0, "R3 R4 R5 R8 vec");

    run_slot(1'b1, 1'b1, 3'd4, 3'd4, 0, 1'b1, "R9 adjacent ones");
    run_slot(1'b1, 1'b0, 3'd4, 3'd4, 8, 1'b1, "R9 sticky");
    run_slot(1'b1, 1'b1, 3'd6, 3'd6, 6, 1'b1, "R5 after rule break");
    run_slot(1'b1, 1'b0, 3'd0, 3'd0, 8, 1'b1, "R3 zero");
    run_slot(1'b1, 1'b1, 3'd0, 3'd0, 0, 1'b1, "R6 delay zero");
    run_slot(1'b1, 1'b0, 3'd2, 3'd2, 8, 1'b1, "R3 zero");
    run_slot(1'b1, 1'b1, 3'd2, 3'd6, 2, 1'b1, "R7 delay raised mid period");
    run_slot(1'b1, 1'b0, 3'd1, 3'd1, 8, 1'b1, "R3 zero");
    run_slot(1'b1, 1'b1, 3'd5, 3'd0, 5, 1'b1, "R7 delay cleared mid period");
    run_slot(1'b0, 1'b1, 3'd3, 3'd3, 8, 1'b1, "R8 idle bit ignored");
    run_slot(1'b1, 1'b1, 3'd3, 3'd3, 3, 1'b1, "R8 idle as zero");
    run_slot(1'b1, 1'b0, 3'd5, 3'd5, 8, 1'b1, "R3 zero");

    // history now ends in one-zero; reset must forget it
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check(in_ready == 1'b1, "R1", "ready after mid reset", int'(in_ready), 1);
    check(rule_err == 1'b0, "R1", "error cleared by reset", int'(rule_err), 0);
    check(wr_strobe == 1'b0, "R1", "strobe after mid reset", int'(wr_strobe), 0);
    run_slot(1'b1, 1'b1, 3'd5, 3'd5, 0, 1'b0, "R1 first bit after reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule